// File: doc/BRIEF.md
# Block sequence number source

This block produces the framing for a sample-processing pipeline that carries no payload of its own. While running, it divides the clock stream into blocks of a fixed number of cycles. It marks the first cycle of each block with a start strobe and the last with an end strobe. Each block carries a 64-bit block sequence number (BSN), and a sync marker goes out on the first block of every sync interval. The interval length is programmed in clock cycles and is meant to be a whole number of blocks.

Software controls the block through a small register port with four word registers. A 64-bit starting BSN is written in two halves. Only the write of the upper half moves the staged value into the live counter. The source can start at once, or it can be armed so that it starts on the next rising edge of a pulse-per-second (PPS) input. Clearing the enable bit stops the source only after the block in progress has finished, so every block that starts also ends.

Top module: `bsn_source`

## Requirements
- R1: After reset, valid_o, sop_o, eop_o and sync_o are 0, bsn_o is 0, and reads of all four registers return 0.
- R2: Register address 0 is the control word: bit 0 is enable and bit 1 is start-on-PPS. Writing 3 while idle arms the source, and valid_o stays 0 until PPS is seen high at a clock edge after having been low at the edge before. valid_o rises in the cycle after that edge.
- R3: A PPS input that is already high when the source is armed does not start it; only a later low-to-high transition does.
- R4: A running source emits blocks of BLOCK_LEN cycles (default 1024) back to back. valid_o is high throughout, sop_o is high on the first cycle of each block and eop_o on the last.
- R5: The first block after a start carries the live BSN, and each later block carries the previous value plus one. The live BSN after a run equals its start value plus the number of blocks emitted.
- R6: A write to address 2 only stages the lower 32 BSN bits and leaves the live BSN unchanged. A write to address 3 loads {written data, staged lower bits} into the live BSN, and the new value is visible from the next cycle.
- R7: Reads combinationally return the control word at address 0, the sync interval at address 1, and the live BSN lower and upper halves at addresses 2 and 3.
- R8: sync_o is high together with sop_o on the first block after every start. After that it is high on every block whose first cycle lies a whole multiple of the address 1 interval (in clock cycles) after the start.
- R9: Clearing the enable bit while running lets the current block finish, including its eop_o. valid_o is 0 from the cycle after that eop_o.
- R10: Writing 1 (enable set, start-on-PPS clear) while idle starts the source immediately: valid_o, sop_o and sync_o are high in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pps_i | input | 1 | Pulse-per-second level, already in the clock domain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| valid_o | output | 1 | Source is emitting a block cycle |
| sop_o | output | 1 | First cycle of a block |
| eop_o | output | 1 | Last cycle of a block |
| sync_o | output | 1 | First block of a sync interval |
| bsn_o | output | 64 | Sequence number of the current block |

## Verification
Every block output comes straight from registers updated at a single edge. A PPS edge or an immediate-start write therefore shows up on valid_o, sop_o and sync_o one cycle later. A write to the upper BSN half is likewise readable one cycle later, and the stop takes effect in the cycle after the eop_o of the block in progress. The bench drives inputs just after the falling edge and samples at the next falling edge. It counts the cycle index of the run from the first valid cycle, and from that index it derives the expected sop, eop, sync, BSN and end of valid for every cycle. Register reads are combinational and are sampled shortly after the read address changes, once the write edge has passed.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SYNC   = 2'd1,
    REG_BSN_LO = 2'd2,
    REG_BSN_HI = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_PPS_BIT = 1;
endpackage

// File: rtl/bsn_regs.sv
module bsn_regs
  import bsn_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BSN_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [BSN_W-1:0]  live_bsn_i,
  output logic              ctrl_wr_o,
  output logic              ctrl_en_o,
  output logic [DATA_W-1:0] sync_len_o,
  output logic              load_o,
  output logic [BSN_W-1:0]  load_val_o
);
  localparam int unsigned HI_W = BSN_W - DATA_W;

  logic [1:0]        ctrl_q, ctrl_d;
  logic [DATA_W-1:0] sync_q, sync_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic              wr_ctrl, wr_sync, wr_lo, wr_hi;

  always_comb begin
    wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
    wr_sync = wr_en_i && (wr_addr_i == REG_SYNC);
    wr_lo   = wr_en_i && (wr_addr_i == REG_BSN_LO);
    wr_hi   = wr_en_i && (wr_addr_i == REG_BSN_HI);
    ctrl_d  = ctrl_q;
    sync_d  = sync_q;
    lo_d    = lo_q;
    if (wr_ctrl) ctrl_d = {wr_data_i[CTRL_PPS_BIT], wr_data_i[CTRL_EN_BIT]};
    if (wr_sync) sync_d = wr_data_i;
    if (wr_lo)   lo_d   = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sync_q <= '0;
      lo_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_sync) sync_q <= sync_d;
      if (wr_lo)   lo_q   <= lo_d;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      REG_CTRL:   rd_data_o = DATA_W'(ctrl_q);
      REG_SYNC:   rd_data_o = sync_q;
      REG_BSN_LO: rd_data_o = live_bsn_i[DATA_W-1:0];
      default:    rd_data_o = DATA_W'(live_bsn_i[BSN_W-1:DATA_W]);
    endcase
  end

  assign ctrl_wr_o  = wr_ctrl;
  assign ctrl_en_o  = ctrl_q[0];
  assign sync_len_o = sync_q;
  assign load_o     = wr_hi;
  assign load_val_o = {wr_data_i[HI_W-1:0], lo_q};

  // R7: the sync interval changes only on a write to its address
  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sync |=> $stable(sync_q));
endmodule

// File: rtl/bsn_starter.sv
module bsn_starter (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_i,
  input  logic ctrl_wr_i,
  input  logic wr_en_bit_i,
  input  logic wr_pps_bit_i,
  input  logic ctrl_en_i,
  input  logic eop_i,
  output logic run_o
);
  logic pps_q;
  logic armed_q, armed_d;
  logic run_q, run_d;
  logic pps_edge;

  assign pps_edge = pps_i && !pps_q;

  always_comb begin
    armed_d = armed_q;
    run_d   = run_q;
    if (run_q) begin
      armed_d = 1'b0;
      if (eop_i && !ctrl_en_i) run_d = 1'b0;
    end else if (ctrl_wr_i) begin
      armed_d = wr_en_bit_i && wr_pps_bit_i;
      run_d   = wr_en_bit_i && !wr_pps_bit_i;
    end else if (armed_q && pps_edge) begin
      armed_d = 1'b0;
      run_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pps_q   <= 1'b0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      pps_q   <= pps_i;
      armed_q <= armed_d;
      run_q   <= run_d;
    end
  end

  assign run_o = run_q;

  // R2: a start follows either a PPS rising edge or a control write
  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(pps_edge) || $past(ctrl_wr_i)));

  // R9: the source only stops right after an end of block
  p_stop_at_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(eop_i));
endmodule

// File: rtl/bsn_counters.sv
module bsn_counters #(
  parameter int unsigned BLOCK_LEN = 1024,
  parameter int unsigned BSN_W     = 64,
  parameter int unsigned SYNC_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [BSN_W-1:0]  load_val_i,
  input  logic [SYNC_W-1:0] sync_len_i,
  output logic              sop_o,
  output logic              eop_o,
  output logic              sync_o,
  output logic [BSN_W-1:0]  bsn_o
);
  localparam int unsigned CW = $clog2(BLOCK_LEN);
  localparam logic [CW-1:0] LAST = CW'(BLOCK_LEN - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [SYNC_W-1:0] scnt_q, scnt_d;
  logic [BSN_W-1:0]  bsn_q, bsn_d;
  logic              last, swrap;

  assign last  = (cnt_q == LAST);
  assign swrap = (sync_len_i != '0) && (scnt_q >= sync_len_i - 1'b1);

  always_comb begin
    if (!run_i)    cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;

    if (!run_i)     scnt_d = '0;
    else if (swrap) scnt_d = '0;
    else            scnt_d = scnt_q + 1'b1;

    if (load_i)              bsn_d = load_val_i;
    else if (run_i && last)  bsn_d = bsn_q + 1'b1;
    else                     bsn_d = bsn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      scnt_q <= '0;
      bsn_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      scnt_q <= scnt_d;
      bsn_q  <= bsn_d;
    end
  end

  assign sop_o  = run_i && (cnt_q == '0);
  assign eop_o  = run_i && last;
  assign sync_o = sop_o && (scnt_q == '0);
  assign bsn_o  = bsn_q;

  // R5: the number steps by one across a block boundary
  p_bsn_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_o && !load_i) |=> (bsn_o == $past(bsn_o) + 1'b1));

  // R6: a load appears on the live number one cycle later
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (bsn_o == $past(load_val_i)));

  // R4: an end of block is followed by a new start or by idle
  p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> (!run_i || sop_o));
endmodule

// File: rtl/bsn_source.sv
module bsn_source
  import bsn_pkg::*;
#(
  parameter int unsigned BLOCK_LEN = 1024,
  parameter int unsigned BSN_W     = 64,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              sync_o,
  output logic [BSN_W-1:0]  bsn_o
);
  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic              ctrl_wr, ctrl_en, load, run;
  logic [DATA_W-1:0] sync_len;
  logic [BSN_W-1:0]  load_val, bsn;
  logic              sop, eop, sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  bsn_regs #(.DATA_W(DATA_W), .BSN_W(BSN_W)) u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .live_bsn_i (bsn),
    .ctrl_wr_o  (ctrl_wr),
    .ctrl_en_o  (ctrl_en),
    .sync_len_o (sync_len),
    .load_o     (load),
    .load_val_o (load_val)
  );

  bsn_starter u_starter (
    .clk          (clk),
    .rst_n        (srst_n),
    .pps_i        (pps_i),
    .ctrl_wr_i    (ctrl_wr),
    .wr_en_bit_i  (wr_data_i[CTRL_EN_BIT]),
    .wr_pps_bit_i (wr_data_i[CTRL_PPS_BIT]),
    .ctrl_en_i    (ctrl_en),
    .eop_i        (eop),
    .run_o        (run)
  );

  bsn_counters #(.BLOCK_LEN(BLOCK_LEN), .BSN_W(BSN_W), .SYNC_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (srst_n),
    .run_i      (run),
    .load_i     (load),
    .load_val_i (load_val),
    .sync_len_i (sync_len),
    .sop_o      (sop),
    .eop_o      (eop),
    .sync_o     (sync),
    .bsn_o      (bsn)
  );

  assign valid_o = run;
  assign sop_o   = sop;
  assign eop_o   = eop;
  assign sync_o  = sync;
  assign bsn_o   = bsn;

  // R8: the first block of every run carries sync
  p_first_sync_r8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(valid_o) |-> (sync_o && sop_o));

  // R1: nothing is framed while the source is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !valid_o |-> !(sop_o || eop_o || sync_o));
endmodule

// File: tb/tb_bsn_source.sv
module tb_bsn_source;
  localparam int  BL     = 1024;
  localparam time CLK_T  = 10ns;
  localparam int  IVL    = 7 * BL;
  localparam int  NVEC   = 13;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // {write?, address, write data, expected read, requirement number}
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 32'd0,      32'd0,      4'd1},
    '{1'b0, 2'd1, 32'd0,      32'd0,      4'd1},
    '{1'b0, 2'd2, 32'd0,      32'd0,      4'd1},
    '{1'b0, 2'd3, 32'd0,      32'd0,      4'd1},
    '{1'b1, 2'd1, IVL,        32'd0,      4'd7},
    '{1'b0, 2'd1, 32'd0,      IVL,        4'd7},
    '{1'b1, 2'd2, 32'd5,      32'd0,      4'd6},
    '{1'b0, 2'd2, 32'd0,      32'd0,      4'd6},
    '{1'b1, 2'd3, 32'd1,      32'd0,      4'd6},
    '{1'b0, 2'd3, 32'd0,      32'd1,      4'd6},
    '{1'b0, 2'd2, 32'd0,      32'd5,      4'd7},
    '{1'b1, 2'd2, 32'd17,     32'd0,      4'd6},
    '{1'b1, 2'd3, 32'd0,      32'd0,      4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pps;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        valid, sop, eop, sync;
  logic [63:0] bsn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  bsn_source #(.BLOCK_LEN(BL)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pps_i     (pps),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .valid_o   (valid),
    .sop_o     (sop),
    .eop_o     (eop),
    .sync_o    (sync),
    .bsn_o     (bsn)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  // Starts at the negedge of the first valid cycle; stop_at < 0 keeps running.
  task automatic watch(input int ncyc, input longint b0, input int stop_at, input string req);
    int vend;
    vend = (stop_at < 0) ? ncyc : ((stop_at + 1) / BL + 1) * BL;
    for (int k = 0; k < ncyc; k++) begin
      if (k < vend) begin
        chk(valid == 1'b1,                              {req, " R4 valid"}, valid, 1);
        chk(sop  == ((k % BL) == 0),                    {req, " R4 sop"},   sop,  (k % BL) == 0);
        chk(eop  == ((k % BL) == BL - 1),               {req, " R4 eop"},   eop,  (k % BL) == BL - 1);
        chk(sync == ((k % BL) == 0 && (k % IVL) == 0),  {req, " R8 sync"},  sync, (k % BL) == 0 && (k % IVL) == 0);
        chk(bsn  == b0 + k / BL,                        {req, " R5 bsn"},   bsn,  b0 + k / BL);
      end else begin
        chk(valid == 1'b0 && sop == 1'b0 && eop == 1'b0, {req, " R9 idle"}, valid, 0);
      end
      if (k == stop_at) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd0;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pps = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk({valid, sop, eop, sync} == 4'b0, "R1 outputs in reset", {valid, sop, eop, sync}, 0);
    chk(bsn == 64'd0, "R1 bsn in reset", bsn, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({valid, sop, eop, sync} == 4'b0, "R1 outputs after reset", {valid, sop, eop, sync}, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else            rd(VECS[i].addr, VECS[i].exp, $sformatf("R%0d table %0d", VECS[i].req, i));
    end
    chk(bsn == 64'd17, "R6 loaded bsn", bsn, 17);

    // R3: PPS high before arming must not start the source
    pps = 1'b1;
    @(negedge clk);
    wr(2'd0, 32'd3);
    rd(2'd0, 32'd3, "R7 control readback");
    repeat (4) begin
      @(negedge clk);
      chk(valid == 1'b0, "R3 held-high PPS ignored", valid, 0);
    end
    // R2: armed source waits while PPS is low
    pps = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(valid == 1'b0, "R2 waiting for PPS", valid, 0);
    end
    pps = 1'b1;
    @(negedge clk);
    chk(valid && sop && sync, "R2 start one cycle after PPS edge", {valid, sop, sync}, 7);
    pps = 1'b0;
    watch(11 * BL, 64'd17, 9 * BL + 300, "R2 pps run");
    rd(2'd2, 32'd27, "R7 live bsn low after run");
    rd(2'd3, 32'd0,  "R7 live bsn high after run");

    // R10: immediate start
    wr(2'd0, 32'd1);
    chk(valid && sop && sync, "R10 immediate start", {valid, sop, sync}, 7);
    watch(3 * BL, 64'd27, BL + 10, "R10 run");
    chk(bsn == 64'd29, "R5 bsn after second run", bsn, 29);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule